// File: doc/BRIEF.md
# Parallel flash command sequencer

This block converts a single request into the series of bus cycles that a byte-wide parallel NOR flash needs for its command set. Three operations are offered: reading the two-byte device identifier, erasing the whole device, and erasing one sector chosen by an address. Each operation is a fixed list of six bus steps. Every list opens with the two-write unlock pair. The identify list also contains two reads and a closing exit write.

A controller raises `req_valid` with an operation code and, for sector erase, the sector address. The sequencer then drives address, write data and the active-low write and read strobes on a simple asynchronous memory bus. When the last bus step has finished it pulses `done`. After an erase it also pulses `erase_issued` in the same cycle, so that a separate completion poller can start. The identifier collected by the identify operation stays on `ident_id` until the next identify.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every operation begins with a bus write of data 0xAA to address 0x5555, followed by a write of 0x55 to address 0x2AAA.
- R2: Identify (req_op 01) continues after the unlock pair with a write of 0x90 to 0x5555, a read at 0x0000, a read at 0x0001, and then a write of 0xF0 to 0x5555.
- R3: After identify, ident_id[7:0] holds the byte read at 0x0000 and ident_id[15:8] holds the byte read at 0x0001. Each byte is taken from bus_rdata in the last strobe cycle of its read. ident_id changes at no other time.
- R4: Chip erase (req_op 10) continues after the unlock pair with writes of 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA and finally 0x10 to 0x5555.
- R5: Sector erase (req_op 11) issues the same first five writes as chip erase. Its sixth write puts 0x30 at the req_addr value captured when the request was accepted.
- R6: Each bus step takes 2+STROBE_CYC cycles. The first is a setup cycle with address and data driven and both strobes high. Then bus_we_n (write) or bus_re_n (read) is low for STROBE_CYC cycles. The last is a hold cycle with both strobes high. Steps follow back to back, the strobes are never low together, and address and data stay stable from setup through hold.
- R7: A request is accepted only when busy is low and req_op is not 00. busy rises the cycle after acceptance and falls the cycle after the final hold cycle. A request that is not accepted produces no bus activity and does not change the operation in progress.
- R8: done is high for exactly one cycle, the cycle in which busy has just fallen, at the end of every operation. erase_issued is high in that same cycle only for chip or sector erase.
- R9: While reset is asserted and after its release with no request, busy, done and erase_issued are low, both strobes are high and ident_id is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 01 identify, 10 chip erase, 11 sector erase, 00 none |
| req_addr | input | AW | Sector address for sector erase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| erase_issued | output | 1 | One-cycle pulse after an erase sequence |
| ident_id | output | 16 | Identifier: device byte high, manufacturer byte low |
| bus_addr | output | AW | Flash byte address |
| bus_wdata | output | 8 | Flash write data |
| bus_rdata | input | 8 | Flash read data |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_re_n | output | 1 | Active-low read strobe |

## Verification
The assertions assume that bus_rdata is stable while the read strobe is low, and that reset is held long enough for the registers to clear. They make no assumption about when requests arrive, because the block has to ignore requests made while it is busy. The bench returns read data as a pure function of the driven address, with identifier values that change only between operations. It also keeps req_valid high through whole sequences and through the cycle in which done is high, so that the ignore rule and back-to-back acceptance are both exercised.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_IDENT = 2'b01,
        OP_CHIP  = 2'b10,
        OP_SECT  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD
    } phase_e;

    localparam int unsigned SEQ_LEN  = 6;
    localparam logic [15:0] MAGIC_HI = 16'h5555;
    localparam logic [15:0] MAGIC_LO = 16'h2AAA;

    typedef struct packed {
        logic        is_rd;
        logic        use_sector;
        logic [15:0] addr;
        logic [7:0]  data;
    } step_t;
endpackage

// File: rtl/nfc_step_rom.sv
module nfc_step_rom
    import nfc_pkg::*;
(
    input  op_e        op,
    input  logic [2:0] idx,
    output step_t      step
);
    always_comb begin
        step = '{is_rd: 1'b0, use_sector: 1'b0, addr: MAGIC_HI, data: 8'hAA};
        case (idx)
            3'd0: step.data = 8'hAA;
            3'd1: begin step.addr = MAGIC_LO; step.data = 8'h55; end
            3'd2: step.data = (op == OP_IDENT) ? 8'h90 : 8'h80;
            3'd3: begin
                if (op == OP_IDENT) begin
                    step.is_rd = 1'b1; step.addr = 16'h0000; step.data = 8'h00;
                end else begin
                    step.data = 8'hAA;
                end
            end
            3'd4: begin
                if (op == OP_IDENT) begin
                    step.is_rd = 1'b1; step.addr = 16'h0001; step.data = 8'h00;
                end else begin
                    step.addr = MAGIC_LO; step.data = 8'h55;
                end
            end
            default: begin
                if (op == OP_IDENT)      step.data = 8'hF0;
                else if (op == OP_SECT)  begin step.use_sector = 1'b1; step.data = 8'h30; end
                else                     step.data = 8'h10;
            end
        endcase
    end
endmodule

// File: rtl/nfc_bus_cycle.sv
module nfc_bus_cycle
    import nfc_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned STROBE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_rd,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_data,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          bus_we_n,
    output logic          bus_re_n,
    output logic          capture,
    output logic          finish
);
    localparam int unsigned CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CYC - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          rd;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } cyc_t;

    cyc_t cyc_d, cyc_q;

    always_comb begin
        cyc_d   = cyc_q;
        capture = 1'b0;
        finish  = 1'b0;
        case (cyc_q.ph)
            PH_SETUP: begin
                cyc_d.ph  = PH_STROBE;
                cyc_d.cnt = '0;
            end
            PH_STROBE: begin
                if (cyc_q.cnt == CNT_LAST) begin
                    cyc_d.ph = PH_HOLD;
                    capture  = cyc_q.rd;
                end else begin
                    cyc_d.cnt = cyc_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                cyc_d.ph = PH_IDLE;
                finish   = 1'b1;
            end
            default: ;
        endcase
        if (start) begin
            cyc_d.ph   = PH_SETUP;
            cyc_d.cnt  = '0;
            cyc_d.rd   = start_rd;
            cyc_d.addr = start_addr;
            cyc_d.data = start_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '{ph: PH_IDLE, cnt: '0, rd: 1'b0, addr: '0, data: '0};
        else        cyc_q <= cyc_d;
    end

    assign bus_addr  = cyc_q.addr;
    assign bus_wdata = cyc_q.data;
    assign bus_we_n  = !(cyc_q.ph == PH_STROBE && !cyc_q.rd);
    assign bus_re_n  = !(cyc_q.ph == PH_STROBE &&  cyc_q.rd);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nfc_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned STROBE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          done,
    output logic          erase_issued,
    output logic [15:0]   ident_id,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata,
    output logic          bus_we_n,
    output logic          bus_re_n
);
    localparam logic [2:0] IDX_LAST = 3'(SEQ_LEN - 1);
    localparam logic [2:0] IDX_RDLO = 3'd3;

    typedef struct packed {
        logic          busy;
        op_e           op;
        logic [AW-1:0] sector;
        logic [2:0]    idx;
        logic [15:0]   id;
        logic          done;
        logic          erase;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic          accept, last_step, start, capture, finish;
    op_e           rom_op;
    logic [2:0]    rom_idx;
    step_t         step;
    logic [AW-1:0] step_addr;

    assign accept    = req_valid && !seq_q.busy && (op_e'(req_op) != OP_NONE);
    assign last_step = (seq_q.idx == IDX_LAST);
    assign rom_op    = accept ? op_e'(req_op) : seq_q.op;
    assign rom_idx   = accept ? 3'd0 : seq_q.idx + 3'd1;
    assign start     = accept || (seq_q.busy && finish && !last_step);
    assign step_addr = step.use_sector ? seq_q.sector : AW'(step.addr);

    nfc_step_rom u_rom (
        .op   (rom_op),
        .idx  (rom_idx),
        .step (step)
    );

    nfc_bus_cycle #(.AW(AW), .STROBE_CYC(STROBE_CYC)) u_cyc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_rd   (step.is_rd),
        .start_addr (step_addr),
        .start_data (step.data),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we_n   (bus_we_n),
        .bus_re_n   (bus_re_n),
        .capture    (capture),
        .finish     (finish)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        seq_d.erase = 1'b0;
        if (accept) begin
            seq_d.busy   = 1'b1;
            seq_d.op     = op_e'(req_op);
            seq_d.sector = req_addr;
            seq_d.idx    = 3'd0;
        end else if (seq_q.busy && finish) begin
            if (last_step) begin
                seq_d.busy  = 1'b0;
                seq_d.done  = 1'b1;
                seq_d.erase = (seq_q.op != OP_IDENT);
            end else begin
                seq_d.idx = seq_q.idx + 3'd1;
            end
        end
        if (capture) begin
            if (seq_q.idx == IDX_RDLO) seq_d.id[7:0]  = bus_rdata;
            else                       seq_d.id[15:8] = bus_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{busy: 1'b0, op: OP_NONE, sector: '0, idx: '0,
                               id: '0, done: 1'b0, erase: 1'b0};
        else        seq_q <= seq_d;
    end

    assign busy         = seq_q.busy;
    assign done         = seq_q.done;
    assign erase_issued = seq_q.erase;
    assign ident_id     = seq_q.id;
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          erase_issued,
    input logic [15:0]   ident_id,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_we_n,
    input logic          bus_re_n
);
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_re_n));

    a_r6_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_we_n) || $fell(bus_re_n)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

    a_r6_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

    a_r6_stable_into_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_we_n) || $rose(bus_re_n)) |-> $stable(bus_addr));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_we_n && bus_re_n));

    a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    a_r8_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r8_erase_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        erase_issued |-> done);

    a_r3_id_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(ident_id));
endmodule

bind nor_cmd_seq nfc_checker #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .erase_issued (erase_issued),
    .ident_id     (ident_id),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we_n     (bus_we_n),
    .bus_re_n     (bus_re_n)
);

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;
    localparam int AW = 16;
    localparam int S  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic          busy, done, erase_issued, bus_we_n, bus_re_n;
    logic [15:0]   ident_id;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic [7:0]    man_byte = 8'h1F;
    logic [7:0]    dev_byte = 8'hD5;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign bus_rdata = (bus_addr == 16'h0000) ? man_byte :
                       (bus_addr == 16'h0001) ? dev_byte : 8'h00;

    nor_cmd_seq #(.AW(AW), .STROBE_CYC(S)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .busy(busy), .done(done), .erase_issued(erase_issued),
        .ident_id(ident_id), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_we_n(bus_we_n), .bus_re_n(bus_re_n)
    );

    typedef struct {
        logic        busy, we_n, re_n, rd, done, er;
        logic [15:0] addr;
        logic [7:0]  data;
        int          tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] last_id = 16'h0000;

    task automatic chk(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One bus step of the model: setup, S strobe cycles, hold (R6)
    task automatic push_step(input logic rd, input logic [15:0] a, input logic [7:0] d, input int tag);
        exp_t e;
        e.busy = 1; e.rd = rd; e.done = 0; e.er = 0; e.addr = a; e.data = d; e.tag = tag;
        e.we_n = 1; e.re_n = 1;
        q.push_back(e);
        for (int i = 0; i < S; i++) begin
            e.we_n = rd; e.re_n = !rd;
            q.push_back(e);
        end
        e.we_n = 1; e.re_n = 1;
        q.push_back(e);
    endtask

    task automatic push_op(input logic [1:0] op, input logic [15:0] sect);
        exp_t e;
        push_step(0, 16'h5555, 8'hAA, 1);        // R1
        push_step(0, 16'h2AAA, 8'h55, 1);        // R1
        if (op == 2'b01) begin
            push_step(0, 16'h5555, 8'h90, 2);    // R2
            push_step(1, 16'h0000, 8'h00, 2);
            push_step(1, 16'h0001, 8'h00, 2);
            push_step(0, 16'h5555, 8'hF0, 2);
            last_id = {dev_byte, man_byte};      // R3
        end else begin
            push_step(0, 16'h5555, 8'h80, (op == 2'b10) ? 4 : 5);  // R4 / R5
            push_step(0, 16'h5555, 8'hAA, (op == 2'b10) ? 4 : 5);
            push_step(0, 16'h2AAA, 8'h55, (op == 2'b10) ? 4 : 5);
            if (op == 2'b10) push_step(0, 16'h5555, 8'h10, 4);
            else             push_step(0, sect, 8'h30, 5);
        end
        e.busy = 0; e.we_n = 1; e.re_n = 1; e.rd = 0; e.done = 1;
        e.er = (op != 2'b01); e.addr = 0; e.data = 0; e.tag = 8;   // R8
        q.push_back(e);
    endtask

    task automatic compare();
        exp_t e;
        if (q.size() > 0) e = q[0];
        else begin
            e.busy = 0; e.we_n = 1; e.re_n = 1; e.rd = 0; e.done = 0; e.er = 0;
            e.addr = 0; e.data = 0; e.tag = 7;
        end
        chk(7, "busy", 32'(busy), 32'(e.busy));               // R7
        chk(6, "we_n", 32'(bus_we_n), 32'(e.we_n));           // R6
        chk(6, "re_n", 32'(bus_re_n), 32'(e.re_n));
        chk(8, "done", 32'(done), 32'(e.done));               // R8
        chk(8, "erase_issued", 32'(erase_issued), 32'(e.er));
        if (e.busy) begin
            chk(e.tag, "bus_addr", 32'(bus_addr), 32'(e.addr));
            if (!e.rd) chk(e.tag, "bus_wdata", 32'(bus_wdata), 32'(e.data));
        end else begin
            chk(3, "ident_id", 32'(ident_id), 32'(last_id)); // R3
        end
    endtask

    task automatic cyc(input logic v, input logic [1:0] op, input logic [15:0] a);
        bit acc;
        req_valid = v; req_op = op; req_addr = a;
        acc = v && (op != 2'b00) && !(q.size() > 0 && q[0].busy);   // R7
        @(posedge clk); #1;
        if (q.size() > 0) void'(q.pop_front());
        if (acc) push_op(op, a);
        @(negedge clk);
        compare();
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] a);
        cyc(1, op, a);
        while (q.size() > 0) cyc(0, 2'b00, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare();                        // R9 reset state
        rst_n = 1;
        repeat (3) cyc(0, 2'b00, 16'h0000);   // R9 idle after release

        run_op(2'b01, 16'h0000);          // R1 R2 R3 identify

        // R7: no-operation code ignored when idle
        repeat (3) cyc(1, 2'b00, 16'h1234);

        // R4 chip erase with competing requests held high while busy (R7)
        cyc(1, 2'b10, 16'h0000);
        repeat (40) cyc(1, 2'b11, 16'h7000);   // sector erase accepted in done cycle
        while (q.size() > 0) cyc(0, 2'b00, 16'h0000);

        // R5 sector erase at extreme addresses
        run_op(2'b11, 16'hFFFF);
        run_op(2'b11, 16'h0000);

        // R3 second identify with new identifier, then erase leaves it alone
        man_byte = 8'hBF; dev_byte = 8'hB6;
        run_op(2'b01, 16'h0000);
        run_op(2'b10, 16'h0000);
        repeat (4) cyc(0, 2'b00, 16'h0000);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R7 watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule